// File: doc/BRIEF.md
# Supervisory Reset Pulse Controller

This block turns several digital fault indications into one stretched system reset. A supply-good flag from an external comparator and an active-low manual reset button hold reset for as long as they are active. A single-cycle watchdog-expiry pulse and a falling level seen on the shared reset pin each start a timed reset. Once every level source has gone quiet, reset stays asserted for a stretch period picked by a 2-bit code and counted in 1 ms ticks from a parameterised prescaler.

The reset pin is bidirectional: the block drives it through an open-drain style enable and reads its level back. A short external low pulse is lengthened to the full stretch period. A low pulse longer than the period releases the internal drive when the period ends, so the pin then follows the external source, and the block never retriggers on its own drive. A second comparator flag drives an active-low low-voltage indication, with a polarity bit choosing between over-voltage and under-voltage. A build option also makes under-voltage on this second input a reset source.

Top module: `rst_stretch_ctrl`

## Requirements
- R1: After reset `rst_drive_n` is 1, `rst_drive` is 0, and `vlow_n` is 1 while the low-voltage condition is inactive.
- R2: While `supply_ok` is low, `rst_drive_n` is 0 from the next clock on. Once it returns high, `rst_drive_n` stays 0 for exactly TICK_DIV x ticks more clocks. A low that lasts H clocks therefore gives a reset pulse of H-1 + TICK_DIV x ticks clocks.
- R3: The stretch length in 1 ms ticks is 25 shifted left by `tmo_sel`: code 0 gives 25, 1 gives 50, 2 gives 100 and 3 gives 200. The code is sampled only when the timer loads, so a change while a count is running does not alter that count.
- R4: A one-cycle high on `wdog_expire` gives a reset pulse of exactly TICK_DIV x ticks clocks. A trigger that arrives during a running count reloads it, and the pulse then ends TICK_DIV x ticks clocks after the latest trigger.
- R5: `mr_n` passes through a two-flop synchronizer and holds reset like `supply_ok` does. A low of H clocks gives a pulse of H-1 + TICK_DIV x ticks clocks.
- R6: A falling edge of the synchronized `pin_level` that occurs while the block is not driving starts one full stretch period, even when the external low is only a few clocks long.
- R7: An external low on the pin that outlasts the period does not extend the drive. The drive ends after exactly one period, no further pulse follows while the pin is held low or when it is released, and falls caused by the block's own drive are ignored.
- R8: `rst_drive` is always the exact complement of `rst_drive_n`.
- R9: `vlow_n` is registered and goes to 0 one clock after the condition holds. With `sense_ov_sel`=1 the condition is `sense_hi`=1 (over-voltage). With `sense_ov_sel`=0 it is `sense_hi`=0 (under-voltage).
- R10: When the parameter SENSE_RST is 1, `sense_hi`=0 holds reset in the same way as `supply_ok` low, whatever the value of `sense_ov_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply comparator flag, 1 = supply above trip level |
| sense_hi | input | 1 | Second comparator flag, 1 = sense input above reference |
| sense_ov_sel | input | 1 | Low-voltage polarity, 1 = flag over-voltage, 0 = flag under-voltage |
| mr_n | input | 1 | Asynchronous active-low manual reset |
| wdog_expire | input | 1 | One-cycle watchdog timeout pulse |
| pin_level | input | 1 | Level read back from the shared reset pin (asynchronous) |
| tmo_sel | input | 2 | Stretch length code |
| rst_drive_n | output | 1 | Active-low reset, 0 = pull the pin low |
| rst_drive | output | 1 | Active-high reset, complement of rst_drive_n |
| vlow_n | output | 1 | Active-low low-voltage flag |

## Verification
A scoreboard predicts the length of every reset pulse from the requirement formulas and compares it with the measured width of `rst_drive_n`. Supply holds of different lengths under the shortest and the longest code separate the hold term from the stretch term. Single and back-to-back watchdog pulses, and a code change in mid-count, show whether the timer reloads and whether the code is latched only at load. Short and very long external pin lows, with the pin modelled as a wired-AND of the block's drive and an external source, show the difference between extension and release-and-follow, and any spurious retrigger would appear as an unexpected pulse. Manual reset, sense under-voltage and both polarities of the low-voltage flag cover the remaining sources.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  // stretch length in 1 ms ticks: base shifted by the 2-bit code
  function automatic int unsigned tmo_ticks(input int unsigned base_ms,
                                            input logic [1:0] sel);
    return base_ms << sel;
  endfunction
endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= INIT;
      s2 <= INIT;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q = s2;
endmodule

// File: rtl/rsc_timer.sv
module rsc_timer #(
  parameter int TICK_DIV = 125000,
  parameter int CW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy,
  output logic          tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;

  assign busy = (cnt_q != '0);
  assign tick = busy && (pre_q == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      pre_q <= '0;
      cnt_q <= load_val;
    end else if (busy) begin
      if (tick) begin
        pre_q <= '0;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rst_stretch_ctrl.sv
module rst_stretch_ctrl #(
  parameter int TICK_DIV  = 125000,
  parameter int BASE_MS   = 25,
  parameter bit SENSE_RST = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       sense_hi,
  input  logic       sense_ov_sel,
  input  logic       mr_n,
  input  logic       wdog_expire,
  input  logic       pin_level,
  input  logic [1:0] tmo_sel,
  output logic       rst_drive_n,
  output logic       rst_drive,
  output logic       vlow_n
);
  import rsc_pkg::*;

  localparam int MAX_TICKS = BASE_MS << 3;
  localparam int CW        = $clog2(MAX_TICKS + 1);

  // named internal events
  logic       mr_s, pin_s, pin_d;
  logic       sense_under;
  logic       sense_hold;
  logic       pin_fall;
  logic       trig_hold;
  logic       trig_fire;
  logic       timer_load;
  logic       busy, tick;
  logic [CW-1:0] load_ticks;
  logic       vlow_cond;
  logic       vlow_q;

  logic [1:0] sync_q;
  rsc_sync #(.W(2), .INIT(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({mr_n, pin_level}), .q(sync_q)
  );
  assign mr_s  = sync_q[1];
  assign pin_s = sync_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_d <= 1'b1;
    else        pin_d <= pin_s;
  end

  assign sense_under = !sense_hi;

  generate
    if (SENSE_RST) begin : g_sense_rst
      assign sense_hold = sense_under;
    end else begin : g_no_sense_rst
      assign sense_hold = 1'b0;
    end
  endgenerate

  // a fall caused by our own drive is ignored
  assign pin_fall   = pin_d && !pin_s && !busy;
  assign trig_hold  = !supply_ok || !mr_s || sense_hold;
  assign trig_fire  = wdog_expire || pin_fall;
  assign timer_load = trig_hold || trig_fire;
  assign load_ticks = CW'(tmo_ticks(BASE_MS, tmo_sel));

  rsc_timer #(.TICK_DIV(TICK_DIV), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(load_ticks),
    .busy(busy), .tick(tick)
  );

  assign vlow_cond = sense_ov_sel ? sense_hi : sense_under;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vlow_q <= 1'b0;
    else        vlow_q <= vlow_cond;
  end

  assign rst_drive_n = !busy;
  assign rst_drive   = busy;
  assign vlow_n      = !vlow_q;
endmodule

// File: rtl/rsc_chk.sv
module rsc_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic sense_hi,
  input logic sense_ov_sel,
  input logic wdog_expire,
  input logic mr_s,
  input logic tick,
  input logic trig_hold,
  input logic rst_drive_n,
  input logic rst_drive,
  input logic vlow_n
);
  // R8
  complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_drive == !rst_drive_n);

  // R2
  supply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !rst_drive_n);

  // R4
  wdog_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_expire |=> !rst_drive_n);

  // R5
  mr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mr_s |=> !rst_drive_n);

  // R2
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_drive_n) |-> ($past(tick) && !$past(trig_hold)));

  // R9
  vlow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_ov_sel ? sense_hi : !sense_hi) |=> !vlow_n);

  // R9
  vlow_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sense_ov_sel ? sense_hi : !sense_hi) |=> vlow_n);
endmodule

bind rst_stretch_ctrl rsc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sense_hi(sense_hi),
  .sense_ov_sel(sense_ov_sel), .wdog_expire(wdog_expire), .mr_s(mr_s),
  .tick(tick), .trig_hold(trig_hold), .rst_drive_n(rst_drive_n),
  .rst_drive(rst_drive), .vlow_n(vlow_n)
);

// File: tb/sim_rst_stretch_ctrl.sv
`timescale 1ns/1ps
module sim_rst_stretch_ctrl;
  localparam int P = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b1, sense_hi = 1'b1, sense_ov_sel = 1'b0;
  logic mr_n = 1'b1, wdog_expire = 1'b0, ext_low = 1'b0;
  logic [1:0] tmo_sel = 2'd0;
  logic pin_level, rst_drive_n, rst_drive, vlow_n;

  always #4 clk = ~clk;

  // wired-AND pin: block drive and external source
  assign pin_level = rst_drive_n && !ext_low;

  rst_stretch_ctrl #(.TICK_DIV(P), .BASE_MS(25), .SENSE_RST(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sense_hi(sense_hi),
    .sense_ov_sel(sense_ov_sel), .mr_n(mr_n), .wdog_expire(wdog_expire),
    .pin_level(pin_level), .tmo_sel(tmo_sel), .rst_drive_n(rst_drive_n),
    .rst_drive(rst_drive), .vlow_n(vlow_n)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  int exp_q[$];
  string tag_q[$];
  int run_len = 0;

  function automatic int ticks_of(input int sel);
    return 25 * (1 << sel);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_pulse(input int len, input string req);
    exp_q.push_back(len);
    tag_q.push_back(req);
  endtask

  // monitor: measure each low pulse of rst_drive_n
  always @(negedge clk) begin
    if (rst_n) begin
      if (!rst_drive_n) run_len++;
      else if (run_len > 0) begin
        if (exp_q.size() == 0) chk(1'b0, "R7 unexpected pulse", run_len, 0);
        else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(run_len == e, t, run_len, e);
        end
        run_len = 0;
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (!rst_drive_n) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic hold_supply(input int h, input int sel);
    tmo_sel = 2'(sel);
    expect_pulse(h - 1 + ticks_of(sel) * P, "R2 supply hold");
    @(negedge clk); supply_ok = 1'b0;
    repeat (h) @(negedge clk);
    supply_ok = 1'b1;
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(rst_drive_n == 1'b1, "R1 rst_drive_n", rst_drive_n, 1);
    chk(rst_drive == 1'b0, "R1 rst_drive", rst_drive, 0);
    chk(vlow_n == 1'b1, "R1 vlow_n", vlow_n, 1);

    // R2 / R3: hold lengths with shortest and longest code
    hold_supply(10, 0);
    hold_supply(5, 3);

    // R4 / R3: single watchdog pulse, code 1
    tmo_sel = 2'd1;
    expect_pulse(ticks_of(1) * P, "R4 wdog single");
    @(negedge clk); wdog_expire = 1'b1;
    @(negedge clk); wdog_expire = 1'b0;
    // R8 complement while active
    chk(rst_drive == !rst_drive_n && !rst_drive_n, "R8 complement", rst_drive, 1);
    wait_idle();

    // R4 reload: second pulse 60 clocks later
    tmo_sel = 2'd0;
    expect_pulse(60 + ticks_of(0) * P, "R4 wdog reload");
    @(negedge clk); wdog_expire = 1'b1;
    @(negedge clk); wdog_expire = 1'b0;
    repeat (59) @(negedge clk);
    wdog_expire = 1'b1;
    @(negedge clk); wdog_expire = 1'b0;
    wait_idle();

    // R3 code change mid-count has no effect
    tmo_sel = 2'd0;
    expect_pulse(ticks_of(0) * P, "R3 code latched at load");
    @(negedge clk); wdog_expire = 1'b1;
    @(negedge clk); wdog_expire = 1'b0;
    repeat (20) @(negedge clk);
    tmo_sel = 2'd3;
    wait_idle();

    // R5 manual reset, code 2
    tmo_sel = 2'd2;
    expect_pulse(7 - 1 + ticks_of(2) * P, "R5 manual reset");
    @(negedge clk); mr_n = 1'b0;
    repeat (7) @(negedge clk);
    mr_n = 1'b1;
    wait_idle();

    // R6 short external pin pulse extended
    tmo_sel = 2'd0;
    expect_pulse(ticks_of(0) * P, "R6 short pin pulse");
    @(negedge clk); ext_low = 1'b1;
    repeat (3) @(negedge clk);
    ext_low = 1'b0;
    wait_idle();

    // R7 long external pin pulse: release after one period, follow pin
    expect_pulse(ticks_of(0) * P, "R7 long pin pulse");
    @(negedge clk); ext_low = 1'b1;
    repeat (ticks_of(0) * P + 50) @(negedge clk);
    chk(rst_drive_n == 1'b1, "R7 drive released while pin low", rst_drive_n, 1);
    ext_low = 1'b0;
    repeat (20) @(negedge clk);
    chk(rst_drive_n == 1'b1, "R7 no retrigger after release", rst_drive_n, 1);

    // R9 polarity: over-voltage flag
    sense_ov_sel = 1'b1;
    repeat (2) @(negedge clk);
    chk(vlow_n == 1'b0, "R9 over-voltage flag", vlow_n, 0);
    sense_ov_sel = 1'b0;
    repeat (2) @(negedge clk);
    chk(vlow_n == 1'b1, "R9 under-voltage inactive", vlow_n, 1);

    // R10 / R9: sense under-voltage holds reset and flags low voltage
    expect_pulse(6 - 1 + ticks_of(0) * P, "R10 sense hold");
    @(negedge clk); sense_hi = 1'b0;
    repeat (2) @(negedge clk);
    chk(vlow_n == 1'b0, "R9 under-voltage flag", vlow_n, 0);
    repeat (4) @(negedge clk);
    sense_hi = 1'b1;
    wait_idle();

    chk(exp_q.size() == 0, "R7 all expected pulses seen", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("[TB] FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule